// File: doc/BRIEF.md
# Frequency Synthesizer Programming Port

This block is the register front end for two frequency synthesizers, one producing the pixel clock and one producing the loop clock. Software reaches it over a byte-wide indexed bus with three live selects: an address register and one data port per synthesizer. A single write to the address register sets a field pointer in each synthesizer at once. Each data port then walks its own synthesizer's divider bytes in the fixed order N, M, P, one byte per access. Programming a synthesizer means pointing it at N and writing three bytes.

The divider bytes drive the synthesizer pins directly. In place of the analog loop, each synthesizer carries a lock model: a write to any divider byte drops lock, and lock returns after a fixed, parameterised number of clocks. Software sees lock by reading the P slot, where bit 6 carries the live lock state in place of the stored bit. Reads answer on a response strobe one cycle after the request. The response has no back-pressure: `rsp_valid` is a one-cycle pulse, and the requester must take `rsp_data` in that cycle.

Top module: `synth_prog_port`

## Requirements
- R1: After reset all six divider bytes are 0x00, both lock outputs are low, both pointers are at N, and `rsp_valid` is low.
- R2: A write with select 0 loads the pixel pointer from data bits 1:0 and the loop pointer from bits 5:4. The codes are 0=N, 1=M and 2=P. Code 3 loads N. The other bits are ignored. A read with select 0 returns the pointers in those same bit positions, with the other bits zero.
- R3: A write with select 1 (pixel) or select 2 (loop) stores the byte in the slot named by that synthesizer's pointer. The byte appears on that synthesizer's divider output after the next rising edge. No other divider byte changes.
- R4: Every accepted read or write on a data port advances only that synthesizer's pointer, in the order N, M, P and back to N.
- R5: A read with select 1 or 2 pulses `rsp_valid` for exactly the cycle after the request. The response carries the stored N or M byte unchanged.
- R6: A read of the P slot returns the stored P byte with bit 6 replaced by that synthesizer's current lock state.
- R7: A write to any divider byte of a synthesizer clears its lock output after the next edge. Lock rises exactly LOCK_CYCLES edges after the last such write, and the other synthesizer's lock is unaffected.
- R8: When read and write are asserted together, only the write is performed. No response is produced, and the pointer advances once.
- R9: Select 3 is unused. Writes to it change nothing, and reads of it return 0x00.
- R10: Writing 0x00 to the address register and then three bytes to a data port programs that synthesizer's N, M and P in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_sel | input | 2 | 0 address, 1 pixel data, 2 loop data, 3 unused |
| bus_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response strobe, one cycle |
| rsp_data | output | 8 | Read response byte |
| pix_n | output | 8 | Pixel synthesizer N divider |
| pix_m | output | 8 | Pixel synthesizer M divider |
| pix_p | output | 8 | Pixel synthesizer P byte |
| pix_lock | output | 1 | Pixel synthesizer lock |
| loop_n | output | 8 | Loop synthesizer N divider |
| loop_m | output | 8 | Loop synthesizer M divider |
| loop_p | output | 8 | Loop synthesizer P byte |
| loop_lock | output | 1 | Loop synthesizer lock |

## Verification
Divider bytes, pointer moves and the drop of lock are all due one edge after the request. The read response is also due one edge after the request. The return of lock is due exactly LOCK_CYCLES edges after the last divider write. A reference model in the bench advances on each rising edge from the same inputs. Every output is compared against it at the following falling edge, so each result is sampled in the first cycle it is due. Directed sequences also count falling edges from a P write until lock shows, and check that the count equals LOCK_CYCLES.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int BYTE_W     = 8;
  localparam int LOCK_BIT   = 6;
  localparam int NCH        = 2;
  localparam int PTR_STRIDE = 4;

  typedef enum logic [1:0] {
    FLD_N = 2'd0,
    FLD_M = 2'd1,
    FLD_P = 2'd2
  } fld_e;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PIX  = 2'd1,
    SEL_LOOP = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  function automatic fld_e fld_from_code(input logic [1:0] code);
    case (code)
      2'd1:    return FLD_M;
      2'd2:    return FLD_P;
      default: return FLD_N;
    endcase
  endfunction

  function automatic fld_e fld_next(input fld_e f);
    case (f)
      FLD_N:   return FLD_M;
      FLD_M:   return FLD_P;
      default: return FLD_N;
    endcase
  endfunction
endpackage

// File: rtl/synth_prog_chan.sv
module synth_prog_chan
  import synth_prog_pkg::*;
#(
  parameter int LOCK_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  fld_e              ptr_init,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] div_n,
  output logic [BYTE_W-1:0] div_m,
  output logic [BYTE_W-1:0] div_p,
  output logic              locked,
  output fld_e              ptr,
  output logic [BYTE_W-1:0] view
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(LOCK_CYCLES);

  logic [CW-1:0]     settle_cnt;
  logic [BYTE_W-1:0] p_view;

  // field pointer and divider storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= FLD_N;
      div_n <= '0;
      div_m <= '0;
      div_p <= '0;
    end else begin
      if (ptr_load) begin
        ptr <= ptr_init;
      end else if (wr_en || rd_en) begin
        ptr <= fld_next(ptr);
      end
      if (wr_en) begin
        case (ptr)
          FLD_N:   div_n <= wdata;
          FLD_M:   div_m <= wdata;
          default: div_p <= wdata;
        endcase
      end
    end
  end

  // lock model: settle counter restarted on every divider write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      locked     <= 1'b0;
    end else if (wr_en) begin
      settle_cnt <= CNT_LOAD;
      locked     <= 1'b0;
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - 1'b1;
      if (settle_cnt == CW'(1)) begin
        locked <= 1'b1;
      end
    end
  end

  always_comb begin
    p_view           = div_p;
    p_view[LOCK_BIT] = locked;
    case (ptr)
      FLD_N:   view = div_n;
      FLD_M:   view = div_m;
      default: view = p_view;
    endcase
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import synth_prog_pkg::*;
#(
  parameter int LOCK_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic [7:0] pix_n,
  output logic [7:0] pix_m,
  output logic [7:0] pix_p,
  output logic       pix_lock,
  output logic [7:0] loop_n,
  output logic [7:0] loop_m,
  output logic [7:0] loop_p,
  output logic       loop_lock
);
  logic              wr_go, rd_go, addr_wr;
  logic [BYTE_W-1:0] div_n [NCH];
  logic [BYTE_W-1:0] div_m [NCH];
  logic [BYTE_W-1:0] div_p [NCH];
  logic [BYTE_W-1:0] view  [NCH];
  logic              lock  [NCH];
  fld_e              ptr   [NCH];
  logic [BYTE_W-1:0] addr_view;
  logic [BYTE_W-1:0] rd_mux;

  // a write takes precedence over a read in the same cycle
  assign wr_go   = bus_wr;
  assign rd_go   = bus_rd && !bus_wr;
  assign addr_wr = wr_go && (bus_sel == SEL_ADDR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_hit;
    assign ch_hit = (bus_sel == 2'(c + 1));
    synth_prog_chan #(.LOCK_CYCLES(LOCK_CYCLES)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_load (addr_wr),
      .ptr_init (fld_from_code(bus_wdata[c*PTR_STRIDE +: 2])),
      .wr_en    (wr_go && ch_hit),
      .rd_en    (rd_go && ch_hit),
      .wdata    (bus_wdata),
      .div_n    (div_n[c]),
      .div_m    (div_m[c]),
      .div_p    (div_p[c]),
      .locked   (lock[c]),
      .ptr      (ptr[c]),
      .view     (view[c])
    );
  end

  always_comb begin
    addr_view = '0;
    for (int c = 0; c < NCH; c++) begin
      addr_view[c*PTR_STRIDE +: 2] = ptr[c];
    end
    case (bus_sel)
      SEL_ADDR: rd_mux = addr_view;
      SEL_PIX:  rd_mux = view[0];
      SEL_LOOP: rd_mux = view[1];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) begin
        rsp_data <= rd_mux;
      end
    end
  end

  assign pix_n     = div_n[0];
  assign pix_m     = div_m[0];
  assign pix_p     = div_p[0];
  assign pix_lock  = lock[0];
  assign loop_n    = div_n[1];
  assign loop_m    = div_m[1];
  assign loop_p    = div_p[1];
  assign loop_lock = lock[1];
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic [7:0] pix_n,
  input logic [7:0] pix_m,
  input logic [7:0] pix_p,
  input logic       pix_lock,
  input logic [7:0] loop_n,
  input logic [7:0] loop_m,
  input logic [7:0] loop_p,
  input logic       loop_lock
);
  a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> rsp_valid);

  a_r8_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> !rsp_valid);

  a_r7_pix_lock_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1) |=> !pix_lock);

  a_r7_loop_lock_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd2) |=> !loop_lock);

  a_r7_pix_lock_unaffected: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd2 && pix_lock) |=> pix_lock);

  a_r3_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel == 2'd1) |=> $stable({pix_n, pix_m, pix_p}));

  a_r3_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel == 2'd2) |=> $stable({loop_n, loop_m, loop_p}));

  a_r9_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == 2'd3) |=> (rsp_data == 8'h00));
endmodule

bind synth_prog_port synth_prog_port_chk u_chk (.*);

// File: tb/synth_prog_port_tb.sv
`timescale 1ns/1ps
module synth_prog_port_tb;
  localparam int LOCK = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic       rsp_valid, pix_lock, loop_lock;
  logic [7:0] rsp_data, pix_n, pix_m, pix_p, loop_n, loop_m, loop_p;

  int checks = 0, errors = 0;
  bit run_chk = 1'b0;

  always #2.5 clk = ~clk;

  synth_prog_port #(.LOCK_CYCLES(LOCK)) u_dut (.*);

  // reference model
  logic [7:0] m_div [2][3];
  logic [1:0] m_ptr [2];
  bit         m_lock [2];
  int         m_cnt [2];
  bit         m_rv;
  logic [7:0] m_rd;

  function automatic logic [1:0] code2ptr(input logic [1:0] c);
    return (c == 2'd3) ? 2'd0 : c;
  endfunction

  function automatic logic [7:0] exp_read(input int s);
    logic [7:0] v;
    if (s == 0) return {2'b00, m_ptr[1], 2'b00, m_ptr[0]};
    if (s == 3) return 8'h00;
    v = m_div[s-1][m_ptr[s-1]];
    if (m_ptr[s-1] == 2'd2) v[6] = m_lock[s-1];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int f = 0; f < 3; f++) m_div[c][f] = 8'h00;
        m_ptr[c] = 2'd0; m_lock[c] = 1'b0; m_cnt[c] = 0;
      end
      m_rv = 1'b0; m_rd = 8'h00;
    end else begin
      automatic bit w = bus_wr;
      automatic bit r = bus_rd && !bus_wr;
      automatic int s = int'(bus_sel);
      m_rv = r;
      if (r) m_rd = exp_read(s);
      for (int c = 0; c < 2; c++) begin
        if (w && s == c + 1) begin
          m_lock[c] = 1'b0; m_cnt[c] = LOCK;
        end else if (m_cnt[c] > 0) begin
          m_cnt[c]--;
          if (m_cnt[c] == 0) m_lock[c] = 1'b1;
        end
      end
      if (w && s == 0) begin
        m_ptr[0] = code2ptr(bus_wdata[1:0]);
        m_ptr[1] = code2ptr(bus_wdata[5:4]);
      end
      for (int c = 0; c < 2; c++) begin
        if ((w || r) && s == c + 1) begin
          if (w) m_div[c][m_ptr[c]] = bus_wdata;
          m_ptr[c] = (m_ptr[c] == 2'd2) ? 2'd0 : m_ptr[c] + 2'd1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (run_chk) begin
      chk("R3 pix dividers",  {pix_n, pix_m, pix_p},   {m_div[0][0], m_div[0][1], m_div[0][2]});
      chk("R3 loop dividers", {loop_n, loop_m, loop_p}, {m_div[1][0], m_div[1][1], m_div[1][2]});
      chk("R7 pix lock",  pix_lock,  m_lock[0]);
      chk("R7 loop lock", loop_lock, m_lock[1]);
      chk("R5 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R6 rsp_data", rsp_data, m_rd);
    end
  end

  // drive one request at a falling edge, return at the next falling edge
  task automatic xfer(input bit w, input bit r, input logic [1:0] s, input logic [7:0] d);
    bus_wr = w; bus_rd = r; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [1:0] s, input logic [7:0] e);
    xfer(1'b0, 1'b1, s, 8'h00);
    chk(tag, {rsp_valid, rsp_data}, {1'b1, e});
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state (sampled while still in reset after edges)
    chk("R1 dividers", {pix_n, pix_m, pix_p, loop_n, loop_m, loop_p}, 48'h0);
    chk("R1 locks/rsp", {pix_lock, loop_lock, rsp_valid}, 3'b000);
    rst_n = 1'b1;
    run_chk = 1'b1;
    @(negedge clk);
    rd_expect("R1 pointers at N", 2'd0, 8'h00);

    // R2: address register decode
    xfer(1'b1, 1'b0, 2'd0, 8'h11);
    rd_expect("R2 addr 0x11", 2'd0, 8'h11);
    xfer(1'b1, 1'b0, 2'd0, 8'hF3);
    rd_expect("R2 code3 loads N, high bits ignored", 2'd0, 8'h00);
    xfer(1'b1, 1'b0, 2'd0, 8'hCE);
    rd_expect("R2 mixed codes", 2'd0, 8'h02);

    // R10: program pixel synth after P reset write; R7 lock timing
    xfer(1'b1, 1'b0, 2'd0, 8'h22);
    xfer(1'b1, 1'b0, 2'd1, 8'h3C);
    chk("R7 pix lock low after write", pix_lock, 1'b0);
    xfer(1'b1, 1'b0, 2'd0, 8'h00);
    xfer(1'b1, 1'b0, 2'd1, 8'h1A);
    xfer(1'b1, 1'b0, 2'd1, 8'h27);
    xfer(1'b1, 1'b0, 2'd1, 8'hF5);
    chk("R10 pix N,M,P", {pix_n, pix_m, pix_p}, 24'h1A27F5);
    chk("R10 loop untouched", {loop_n, loop_m, loop_p}, 24'h0);
    n = 0;
    while (!pix_lock && n < 1000) begin @(negedge clk); n++; end
    chk("R7 lock delay", n, LOCK);
    chk("R7 loop lock unaffected", loop_lock, 1'b0);

    // R6: P read shows lock in bit 6; R4: loop pointer unaffected by pixel reads
    rd_expect("R5 N read", 2'd1, 8'h1A);
    rd_expect("R5 M read", 2'd1, 8'h27);
    rd_expect("R6 P read locked", 2'd1, 8'hF5);
    rd_expect("R4 pixel wraps, loop still N", 2'd0, 8'h00);

    // program loop synth, check pixel lock stays
    xfer(1'b1, 1'b0, 2'd0, 8'h22);
    xfer(1'b1, 1'b0, 2'd2, 8'h70);
    xfer(1'b1, 1'b0, 2'd0, 8'h00);
    xfer(1'b1, 1'b0, 2'd2, 8'h05);
    xfer(1'b1, 1'b0, 2'd2, 8'h09);
    xfer(1'b1, 1'b0, 2'd2, 8'h41);
    chk("R7 pixel lock held across loop writes", pix_lock, 1'b1);
    xfer(1'b1, 1'b0, 2'd0, 8'h20);
    rd_expect("R6 P read unlocked", 2'd2, 8'h01);

    // R8: write beats read
    xfer(1'b1, 1'b0, 2'd0, 8'h00);
    xfer(1'b1, 1'b1, 2'd1, 8'h99);
    chk("R8 no response", rsp_valid, 1'b0);
    chk("R8 write done", pix_n, 8'h99);
    rd_expect("R8 single advance", 2'd0, 8'h01);

    // R9: unused select
    xfer(1'b1, 1'b0, 2'd3, 8'hAB);
    chk("R9 write ignored", {pix_n, pix_m, pix_p, loop_n, loop_m, loop_p}, {8'h99, 8'h27, 8'hF5, 8'h05, 8'h09, 8'h41});
    rd_expect("R9 read zero", 2'd3, 8'h00);

    // constrained random traffic checked against the model
    for (int i = 0; i < 6000; i++) begin
      automatic int roll = $urandom_range(0, 99);
      automatic logic [1:0] s = 2'($urandom_range(0, 3));
      automatic logic [7:0] d = 8'($urandom);
      automatic bit w = (roll < 15);
      automatic bit r = (roll >= 10 && roll < 50);
      if (s == 2'd0 && w) d = {2'b00, 2'($urandom), 2'b00, 2'($urandom)};
      xfer(w, r, s, d);
    end
    repeat (LOCK + 2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule